// File: doc/BRIEF.md
# Shift-Immediate Decode and Execute Unit

This unit takes a 32-bit instruction word and an operand. It recognises the three integer shift-by-immediate operations: logical left, logical right and arithmetic right. It checks every fixed bit of the word and produces the shifted value. A width input selects the narrow register width (32 bits) or the wide one (64 bits). The split between the fixed bits and the shift-amount field depends on that width. In narrow mode the shift amount has five bits and seven upper bits are fixed. In wide mode the shift amount has six bits and only six upper bits are fixed.

Decoding is exact. A word that matches the opcode and operation field but differs in any fixed upper bit is reported as illegal; it is never shifted. One pattern gets special treatment in narrow mode: the left-shift word whose lowest fixed bit (bit 25) is set. This pattern is a custom encoding, so the unit raises a custom-hit flag for it instead of the illegal flag. In wide mode the same word is an ordinary left shift with shift-amount bit 5 set.

All outputs are registered one clock after the valid strobe. The shifter is built either as a chain of logarithmic stages or as a plain behavioural shift, chosen by a parameter.

Top module: `shimm_unit`

## Requirements
- R1: A synchronous active-high reset clears every output (flags, destination index and result) at the next rising clock edge.
- R2: Outputs are registered. One cycle after a valid word, `dst_idx` equals bits [11:7] of that word. In a cycle after valid was low, all three flags are zero and `dst_idx` and `result` keep their previous values.
- R3: A valid word whose bits [6:0] differ from 0010011, or whose bits [14:12] are neither 001 nor 101, gives all three flags low and a zero result.
- R4: In narrow mode (`wide_mode`=0), funct3 001 is legal only with bits [31:25]=0000000, and funct3 101 is legal only with bits [31:25]=0000000 (logical) or 0100000 (arithmetic). Every other upper pattern is illegal, except the one covered by R5.
- R5: In narrow mode, a word with bits [31:25]=0000001, funct3 001 and opcode 0010011 raises `cust_hit`, with both `ok_legal` and `bad_illegal` low.
- R6: In wide mode (`wide_mode`=1), bits [31:26] must be 000000 for funct3 001 or 101, or 010000 for funct3 101 (arithmetic). Bit 25 belongs to the shift amount. Any other pattern is illegal, and `cust_hit` never rises.
- R7: At most one of `ok_legal`, `bad_illegal` and `cust_hit` is high in any cycle.
- R8: In narrow mode, a legal shift acts on `src_val`[31:0] by bits [24:20] of the word. The result's upper 32 bits are zero. An arithmetic right shift fills with bit 31 of the operand.
- R9: In wide mode, a legal shift acts on the full 64-bit `src_val` by bits [25:20] of the word. An arithmetic right shift fills with bit 63.
- R10: After a valid word that is not legal (illegal, custom or out-of-unit), `result` is zero.
- R11: Both shifter implementations (SHIFT_IMPL 0 and 1) produce identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking `insn` and `src_val` as valid |
| insn | input | 32 | Instruction word |
| wide_mode | input | 1 | 0 = narrow (32-bit) width, 1 = wide (64-bit) width |
| src_val | input | 64 | Source operand value |
| dst_idx | output | 5 | Destination register index from the word |
| result | output | 64 | Shifted value, zero unless legal |
| ok_legal | output | 1 | Word is a legal shift for the selected width |
| bad_illegal | output | 1 | Word matches opcode and funct3 but breaks a fixed-bit rule |
| cust_hit | output | 1 | Word is the narrow-mode custom encoding |

## Verification
The bench builds two copies side by side with the default 64-bit data width. One copy uses the logarithmic shifter (SHIFT_IMPL=1) and the other the behavioural shifter (SHIFT_IMPL=0). Their outputs are compared on every stimulus, which checks that the generate variants agree. The bench sweeps all 128 upper seven-bit patterns for both shift funct3 values in both width modes. This sweep reaches every near-miss encoding, including the bit-25 word that changes meaning between the modes. Directed cases add shift amounts 0, 31 and 63 with sign-bit operands.

// File: rtl/shimm_pkg.sv
package shimm_pkg;

   localparam logic [6:0] OPC_SHIMM  = 7'b0010011;
   localparam logic [2:0] F3_LEFT    = 3'b001;
   localparam logic [2:0] F3_RIGHT   = 3'b101;
   localparam logic [6:0] TOP_PLAIN  = 7'b0000000;
   localparam logic [6:0] TOP_ARITH  = 7'b0100000;
   localparam logic [6:0] TOP_CUSTOM = 7'b0000001;
   localparam int unsigned SHAMT_W   = 6;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RIGHT = 2'd1,
      SK_ARITH = 2'd2
   } shift_kind_e;

   typedef struct packed {
      logic                 legal;
      logic                 illegal;
      logic                 custom;
      shift_kind_e          kind;
      logic [SHAMT_W-1:0]   shamt;
      logic [4:0]           rd;
   } shimm_dec_t;

endpackage

// File: rtl/shimm_decode.sv
module shimm_decode
   import shimm_pkg::*;
(
   input  logic [31:0] insn,
   input  logic        wide_mode,
   output shimm_dec_t  dec
);

   logic [2:0] f3;
   logic [6:0] top7;
   logic [5:0] top6;
   logic       opc_hit;
   logic       f3_hit;
   logic       unused_rs1;

   assign f3         = insn[14:12];
   assign top7       = insn[31:25];
   assign top6       = insn[31:26];
   assign opc_hit    = (insn[6:0] == OPC_SHIMM);
   assign f3_hit     = (f3 == F3_LEFT) || (f3 == F3_RIGHT);
   assign unused_rs1 = ^insn[19:15];

   always_comb begin
      dec         = '0;
      dec.kind    = SK_LEFT;
      dec.rd      = insn[11:7];
      if (opc_hit && f3_hit) begin
         if (wide_mode) begin
            dec.shamt = insn[25:20];
            if (f3 == F3_LEFT) begin
               if (top6 == TOP_PLAIN[6:1]) begin
                  dec.legal = 1'b1;
                  dec.kind  = SK_LEFT;
               end else begin
                  dec.illegal = 1'b1;
               end
            end else begin
               if (top6 == TOP_PLAIN[6:1]) begin
                  dec.legal = 1'b1;
                  dec.kind  = SK_RIGHT;
               end else if (top6 == TOP_ARITH[6:1]) begin
                  dec.legal = 1'b1;
                  dec.kind  = SK_ARITH;
               end else begin
                  dec.illegal = 1'b1;
               end
            end
         end else begin
            dec.shamt = {1'b0, insn[24:20]};
            if (f3 == F3_LEFT) begin
               if (top7 == TOP_PLAIN) begin
                  dec.legal = 1'b1;
                  dec.kind  = SK_LEFT;
               end else if (top7 == TOP_CUSTOM) begin
                  dec.custom = 1'b1;
               end else begin
                  dec.illegal = 1'b1;
               end
            end else begin
               if (top7 == TOP_PLAIN) begin
                  dec.legal = 1'b1;
                  dec.kind  = SK_RIGHT;
               end else if (top7 == TOP_ARITH) begin
                  dec.legal = 1'b1;
                  dec.kind  = SK_ARITH;
               end else begin
                  dec.illegal = 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/shimm_shift.sv
module shimm_shift
   import shimm_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned SHIFT_IMPL = 1,
   localparam int unsigned HALF_W    = DATA_W / 2,
   localparam int unsigned SH_W      = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [SH_W-1:0]   amount,
   input  shift_kind_e       kind,
   input  logic              narrow,
   output logic [DATA_W-1:0] shifted
);

   logic              fill;
   logic [DATA_W-1:0] ext;
   logic [DATA_W-1:0] left_v;
   logic [DATA_W-1:0] right_v;
   logic [DATA_W-1:0] pick;

   assign fill = (kind == SK_ARITH) &&
                 (narrow ? operand[HALF_W-1] : operand[DATA_W-1]);
   assign ext  = narrow ? {{HALF_W{fill}}, operand[HALF_W-1:0]} : operand;

   generate
      if (SHIFT_IMPL == 0) begin : g_behav
         assign left_v  = ext << amount;
         assign right_v = fill ? ~((~ext) >> amount) : (ext >> amount);
      end else begin : g_stages
         logic [DATA_W-1:0] lstage [SH_W+1];
         logic [DATA_W-1:0] rstage [SH_W+1];
         assign lstage[0] = ext;
         assign rstage[0] = ext;
         for (genvar k = 0; k < SH_W; k++) begin : g_step
            localparam int unsigned STEP = 1 << k;
            assign lstage[k+1] = amount[k]
               ? {lstage[k][DATA_W-1-STEP:0], {STEP{1'b0}}}
               : lstage[k];
            assign rstage[k+1] = amount[k]
               ? {{STEP{fill}}, rstage[k][DATA_W-1:STEP]}
               : rstage[k];
         end
         assign left_v  = lstage[SH_W];
         assign right_v = rstage[SH_W];
      end
   endgenerate

   assign pick    = (kind == SK_LEFT) ? left_v : right_v;
   assign shifted = narrow ? {{HALF_W{1'b0}}, pick[HALF_W-1:0]} : pick;

endmodule

// File: rtl/shimm_outreg.sv
module shimm_outreg
   import shimm_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  shimm_dec_t        dec,
   input  logic [DATA_W-1:0] value,
   output logic [4:0]        dst_q,
   output logic [DATA_W-1:0] value_q,
   output logic              legal_q,
   output logic              illegal_q,
   output logic              custom_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         dst_q     <= '0;
         value_q   <= '0;
         legal_q   <= 1'b0;
         illegal_q <= 1'b0;
         custom_q  <= 1'b0;
      end else if (valid) begin
         dst_q     <= dec.rd;
         value_q   <= dec.legal ? value : '0;
         legal_q   <= dec.legal;
         illegal_q <= dec.illegal;
         custom_q  <= dec.custom;
      end else begin
         legal_q   <= 1'b0;
         illegal_q <= 1'b0;
         custom_q  <= 1'b0;
      end
   end

endmodule

// File: rtl/shimm_unit.sv
module shimm_unit
   import shimm_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned SHIFT_IMPL = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [31:0]       insn,
   input  logic              wide_mode,
   input  logic [DATA_W-1:0] src_val,
   output logic [4:0]        dst_idx,
   output logic [DATA_W-1:0] result,
   output logic              ok_legal,
   output logic              bad_illegal,
   output logic              cust_hit
);

   localparam int unsigned SH_W = $clog2(DATA_W);

   generate
      if (DATA_W != 64) begin : g_bad_width
         $error("shimm_unit: DATA_W must be 64 to match the 6-bit wide shift field");
      end
      if (SHIFT_IMPL > 1) begin : g_bad_impl
         $error("shimm_unit: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   shimm_dec_t        dec;
   logic [DATA_W-1:0] shifted;

   shimm_decode u_dec (
      .insn      (insn),
      .wide_mode (wide_mode),
      .dec       (dec)
   );

   shimm_shift #(
      .DATA_W     (DATA_W),
      .SHIFT_IMPL (SHIFT_IMPL)
   ) u_shift (
      .operand (src_val),
      .amount  (dec.shamt[SH_W-1:0]),
      .kind    (dec.kind),
      .narrow  (!wide_mode),
      .shifted (shifted)
   );

   shimm_outreg #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk       (clk),
      .rst       (rst),
      .valid     (in_valid),
      .dec       (dec),
      .value     (shifted),
      .dst_q     (dst_idx),
      .value_q   (result),
      .legal_q   (ok_legal),
      .illegal_q (bad_illegal),
      .custom_q  (cust_hit)
   );

endmodule

// File: rtl/shimm_unit_chk.sv
module shimm_unit_chk #(
   parameter int unsigned DATA_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [31:0]       insn,
   input logic              wide_mode,
   input logic [4:0]        dst_idx,
   input logic [DATA_W-1:0] result,
   input logic              ok_legal,
   input logic              bad_illegal,
   input logic              cust_hit
);

   localparam int unsigned HALF_W = DATA_W / 2;

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (dst_idx == '0 && result == '0 && !ok_legal && !bad_illegal && !cust_hit));

   a_r2_idle_flags_low: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!ok_legal && !bad_illegal && !cust_hit));

   a_r2_dst_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (dst_idx == $past(insn[11:7])));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(result) && $stable(dst_idx)));

   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ok_legal, bad_illegal, cust_hit}));

   a_r5_custom_only_narrow: assert property (@(posedge clk) disable iff (rst)
      (in_valid && wide_mode) |=> !cust_hit);

   a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !wide_mode) |=> (result[DATA_W-1:HALF_W] == '0));

   a_r10_zero_unless_legal: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (ok_legal || result == '0));

endmodule

bind shimm_unit shimm_unit_chk #(.DATA_W(DATA_W)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .insn        (insn),
   .wide_mode   (wide_mode),
   .dst_idx     (dst_idx),
   .result      (result),
   .ok_legal    (ok_legal),
   .bad_illegal (bad_illegal),
   .cust_hit    (cust_hit)
);

// File: tb/shimm_unit_tb_top.sv
module shimm_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic        wide_mode = 1'b0;
   logic [63:0] src_val = '0;

   logic [4:0]  dst_idx,  dst_b;
   logic [63:0] result,   result_b;
   logic        ok_legal, ok_b;
   logic        bad_illegal, bad_b;
   logic        cust_hit, cust_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   shimm_unit #(.DATA_W(64), .SHIFT_IMPL(1)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .wide_mode(wide_mode), .src_val(src_val), .dst_idx(dst_idx),
      .result(result), .ok_legal(ok_legal), .bad_illegal(bad_illegal),
      .cust_hit(cust_hit));

   shimm_unit #(.DATA_W(64), .SHIFT_IMPL(0)) dut_alt (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .wide_mode(wide_mode), .src_val(src_val), .dst_idx(dst_b),
      .result(result_b), .ok_legal(ok_b), .bad_illegal(bad_b),
      .cust_hit(cust_b));

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [6:0] top, input logic [4:0] sh,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [6:0] opc);
      return {top, sh, 5'd9, f3, rd, opc};
   endfunction

   // Reference model written from the requirements
   task automatic model(input logic [31:0] w, input bit wide, input logic [63:0] a,
                        output logic [2:0] flags, output logic [63:0] r);
      logic [2:0]  f;
      logic [31:0] n;
      logic signed [31:0] ns;
      logic signed [63:0] ws;
      f = w[14:12];
      flags = 3'b000;  // {legal, illegal, custom}
      r = '0;
      if (w[6:0] != 7'b0010011 || !(f == 3'b001 || f == 3'b101)) return;
      if (!wide) begin
         ns = a[31:0];
         if (f == 3'b001) begin
            if (w[31:25] == 7'b0000000) begin
               flags = 3'b100; n = a[31:0] << w[24:20]; r = {32'h0, n};
            end else if (w[31:25] == 7'b0000001) flags = 3'b001;
            else flags = 3'b010;
         end else begin
            if (w[31:25] == 7'b0000000) begin
               flags = 3'b100; n = a[31:0] >> w[24:20]; r = {32'h0, n};
            end else if (w[31:25] == 7'b0100000) begin
               flags = 3'b100; n = ns >>> w[24:20]; r = {32'h0, n};
            end else flags = 3'b010;
         end
      end else begin
         ws = a;
         if (f == 3'b001) begin
            if (w[31:26] == 6'b000000) begin flags = 3'b100; r = a << w[25:20]; end
            else flags = 3'b010;
         end else begin
            if (w[31:26] == 6'b000000) begin flags = 3'b100; r = a >> w[25:20]; end
            else if (w[31:26] == 6'b010000) begin flags = 3'b100; r = ws >>> w[25:20]; end
            else flags = 3'b010;
         end
      end
   endtask

   task automatic apply(input logic [31:0] w, input bit wide, input logic [63:0] a);
      @(negedge clk);
      insn = w; wide_mode = wide; src_val = a; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic cmp_alt();
      check("R11", "alt flags", {61'h0, ok_b, bad_b, cust_b},
            {61'h0, ok_legal, bad_illegal, cust_hit});
      check("R11", "alt result", result_b, result);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "flags after reset", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'h0);
      check("R1", "result after reset", result, 64'h0);
      check("R1", "dst after reset", {59'h0, dst_idx}, 64'h0);
      rst = 1'b0;
   endtask

   task automatic t_sweep();
      for (int m = 0; m < 2; m++) begin
         for (int fi = 0; fi < 2; fi++) begin
            for (int t = 0; t < 128; t++) begin
               logic [2:0]  f3;
               logic [31:0] w;
               logic [63:0] a;
               logic [2:0]  ef;
               logic [63:0] er;
               string       rq;
               f3 = (fi == 0) ? 3'b001 : 3'b101;
               w  = mk(t[6:0], 5'd13, f3, t[4:0], 7'b0010011);
               a  = t[0] ? 64'hF0E1_D2C3_B4A5_9687 : 64'h7654_3210_0FED_CBA9;
               model(w, m[0], a, ef, er);
               apply(w, m[0], a);
               if (m == 0) rq = (fi == 0 && t == 1) ? "R5" : "R4";
               else rq = "R6";
               check(rq, "flags", {61'h0, ok_legal, bad_illegal, cust_hit}, {61'h0, ef});
               check((m == 0) ? "R8" : "R9", "result", result, er);
               check("R7", "flag count", 64'($countones({ok_legal, bad_illegal, cust_hit}) <= 1), 64'd1);
               check("R2", "dst", {59'h0, dst_idx}, {59'h0, w[11:7]});
               if (ef[2] == 1'b0) check("R10", "non-legal result", result, 64'h0);
               cmp_alt();
            end
         end
      end
   endtask

   task automatic t_custom();
      apply(mk(7'b0000001, 5'd4, 3'b001, 5'd3, 7'b0010011), 1'b0, 64'h1);
      check("R5", "narrow custom flags", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'b001);
      check("R10", "custom result", result, 64'h0);
      apply(mk(7'b0000001, 5'd4, 3'b001, 5'd3, 7'b0010011), 1'b1, 64'h1);
      check("R6", "wide bit25 is shamt flags", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'b100);
      check("R6", "wide bit25 shift by 36", result, 64'h0000_0010_0000_0000);
   endtask

   task automatic t_amounts();
      apply(mk(7'b0000000, 5'd0, 3'b101, 5'd1, 7'b0010011), 1'b0, 64'h1234_5678_9ABC_DEF0);
      check("R8", "narrow shift 0", result, 64'h0000_0000_9ABC_DEF0);
      apply(mk(7'b0000000, 5'd31, 3'b001, 5'd1, 7'b0010011), 1'b0, 64'hFFFF_FFFF_0000_0003);
      check("R8", "narrow left 31", result, 64'h0000_0000_8000_0000);
      apply(mk(7'b0000000, 5'd31, 3'b101, 5'd1, 7'b0010011), 1'b0, 64'hFFFF_FFFF_8000_0000);
      check("R8", "narrow logical right 31", result, 64'h1);
      apply(mk(7'b0100000, 5'd31, 3'b101, 5'd1, 7'b0010011), 1'b0, 64'hFFFF_FFFF_8000_0000);
      check("R8", "narrow arith right 31", result, 64'h0000_0000_FFFF_FFFF);
      cmp_alt();
      apply(mk(7'b0000000, 5'd0, 3'b101, 5'd2, 7'b0010011), 1'b1, 64'h8123_4567_89AB_CDEF);
      check("R9", "wide shift 0", result, 64'h8123_4567_89AB_CDEF);
      apply(mk(7'b0000001, 5'd31, 3'b001, 5'd2, 7'b0010011), 1'b1, 64'h1);
      check("R9", "wide left 63", result, 64'h8000_0000_0000_0000);
      apply(mk(7'b0000001, 5'd31, 3'b101, 5'd2, 7'b0010011), 1'b1, 64'h8000_0000_0000_0001);
      check("R9", "wide logical right 63", result, 64'h1);
      apply(mk(7'b0100001, 5'd31, 3'b101, 5'd2, 7'b0010011), 1'b1, 64'h8000_0000_0000_0001);
      check("R9", "wide arith right 63", result, 64'hFFFF_FFFF_FFFF_FFFF);
      cmp_alt();
   endtask

   task automatic t_outside();
      apply(mk(7'b0000000, 5'd3, 3'b001, 5'd4, 7'b0110011), 1'b0, 64'hFF);
      check("R3", "wrong opcode flags", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'h0);
      check("R3", "wrong opcode result", result, 64'h0);
      apply(mk(7'b0000001, 5'd3, 3'b011, 5'd4, 7'b0010011), 1'b0, 64'hFF);
      check("R3", "other funct3 flags", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'h0);
      apply(mk(7'b0100000, 5'd3, 3'b000, 5'd4, 7'b0010011), 1'b1, 64'hFF);
      check("R3", "funct3 000 wide flags", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'h0);
      check("R3", "funct3 000 wide result", result, 64'h0);
   endtask

   task automatic t_idle();
      apply(mk(7'b0000000, 5'd4, 3'b001, 5'd17, 7'b0010011), 1'b1, 64'h3);
      check("R2", "legal before idle", {63'h0, ok_legal}, 64'h1);
      @(negedge clk);
      insn = mk(7'b1111111, 5'd0, 3'b001, 5'd5, 7'b0010011);
      @(negedge clk);
      check("R2", "idle flags low", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'h0);
      check("R2", "idle result held", result, 64'h30);
      check("R2", "idle dst held", {59'h0, dst_idx}, 64'd17);
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_custom();
      t_amounts();
      t_outside();
      t_idle();
      rst = 1'b1;
      @(negedge clk);
      check("R1", "reset mid-run", {61'h0, ok_legal, bad_illegal, cust_hit}, 64'h0);
      check("R1", "reset mid-run result", result, 64'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule